// File: doc/BRIEF.md
# Packet Header Router With Arbitration

This block is the packet-routed half of a stream crossbar. Several 32-bit AXI4-Stream inputs carry packets. Each packet starts with a header word, may carry data words after it, and ends on the word marked with TLAST. The block reads the header and checks its parity. It then uses the 5-bit stream ID in the header to look up a table, which returns the set of outputs that should receive the packet. A packet can go to one output or to several at once (multicast).

Each output can carry only one packet at a time. When an output is handed to an input, it stays with that input until the input's TLAST word has been delivered on it. Inputs that are waiting for free outputs are served in round-robin order. A multicast packet is given all of its outputs in one step. A packet with bad header parity is thrown away and raises an error flag that stays set. A packet whose ID maps to no outputs is thrown away without any error.

Software loads the routing table through a simple write port. The table holds one output mask per stream ID. Several logical streams can share the same physical inputs and outputs, so the time a packet takes to get through depends on contention.

Top module: `pkt_router`

## Requirements
- R1: A header word with an even number of ones across all 32 bits is a parity error. The whole packet, up to and including its TLAST word, is accepted from the input and delivered nowhere. `hdr_err` goes high and stays high until reset.
- R2: Bits 4:0 of the header select one of 32 table entries. Bit d of the entry's mask sends the packet to output d. A write with `cfg_we` high stores `cfg_mask` at entry `cfg_id` on the clock edge. Reset clears every entry. The mask is captured when the header arrives, so a later table write does not change where a packet already under way is sent.
- R3: A header with good parity whose entry is all zeros is accepted and its packet discarded. No output sees any word of it and `hdr_err` does not change.
- R4: Each destination receives the header word unchanged as the first word, then the data words in order. TLAST is high only on the final word.
- R5: An output that has started a packet carries no word from any other packet until that packet's TLAST word has been delivered. No output is ever handed to two inputs.
- R6: A multicast packet reaches every output in its mask, and each output receives each word exactly once. The input word is taken only after every destination has accepted it, so one stalled destination holds the input.
- R7: Inputs waiting for the same output are granted in round-robin order. No input gets a second packet through an output while another input is still waiting for that output.
- R8: Once an output raises TVALID, it keeps TVALID and TDATA steady until TREADY is seen.
- R9: After reset, every `m_tvalid` is low, every `s_tready` is low while its input is idle, and `hdr_err` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| s_tdata | input | N_IN*32 | Input words; input i uses bits [i*32 +: 32] |
| s_tvalid | input | N_IN | Input word valid, one bit per input |
| s_tlast | input | N_IN | Marks the last word of a packet |
| s_tready | output | N_IN | Input word accepted |
| m_tdata | output | N_OUT*32 | Output words; output d uses bits [d*32 +: 32] |
| m_tvalid | output | N_OUT | Output word valid |
| m_tlast | output | N_OUT | Marks the last word of a packet |
| m_tready | input | N_OUT | Downstream accepts the output word |
| cfg_we | input | 1 | Table write strobe |
| cfg_id | input | 5 | Stream ID (table entry) to write |
| cfg_mask | input | N_OUT | Output mask to store |
| hdr_err | output | 1 | Sticky header parity error flag |

## Verification
The bench holds one multicast destination not-ready while the other destination drains. A design that lets the input move on would deliver a word twice or lose one on the stalled output.

Three inputs are queued behind a long packet that holds one output. When that output is freed, the order in which the queued inputs are served is checked: a fixed-priority design would hand the output back to the same input before the third input has had a turn.

A packet with corrupted parity is followed by a good packet from the same input. This catches a design that stops discarding too early, which would leak data words, and a design that never resumes. Random traffic mixes single-output, multicast and zero-mask IDs under random backpressure, and every delivered word is compared against its source-encoded expected value. A packet interleaved with another on one output would show up as a mismatch.

// File: rtl/pkt_router_pkg.sv
// Package pkt_router_pkg
// Shared types for the packet router: the state of one input port.
// Assumes nothing beyond the IEEE 1800-2017 language.
package pkt_router_pkg;

    // Life cycle of one input: idle, waiting for outputs, moving words, discarding.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_XFER = 2'd2,
        ST_DROP = 2'd3
    } in_state_e;

    // Number of low header bits that carry the stream ID.
    localparam int SID_W = 5;

endpackage

// File: rtl/pr_id_table.sv
// Module pr_id_table
// Routing table: one output mask per stream ID. Written one entry at a time.
// Every input has its own combinational read port.
// Assumes the write and the reads share one clock. A read sees the stored value,
// so a write shows up on the reads one cycle after it is made.
module pr_id_table #(
    parameter int N_OUT = 6,
    parameter int ID_W  = 5,
    parameter int N_RD  = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ID_W-1:0]                wr_id,
    input  logic [N_OUT-1:0]               wr_mask,
    input  logic [N_RD-1:0][ID_W-1:0]      rd_id,
    output logic [N_RD-1:0][N_OUT-1:0]     rd_mask
);
    localparam int DEPTH = 1 << ID_W;

    logic [DEPTH-1:0][N_OUT-1:0] entry;

    // Store one mask per write; reset empties the table.
    always_ff @(posedge clk) begin
        if (!rst_n)
            entry <= '0;
        else if (wr_en)
            entry[wr_id] <= wr_mask;
    end

    // One read port per input.
    for (genvar r = 0; r < N_RD; r++) begin : g_rd
        assign rd_mask[r] = entry[rd_id[r]];
    end
endmodule

// File: rtl/pr_in_ctrl.sv
// Module pr_in_ctrl
// Handles one input port. It checks the header parity, captures the routing mask
// and asks the allocator for the outputs. It then moves words, tracking which
// destinations have already taken the current word so that each word is delivered
// exactly once per destination.
// Assumes the input follows AXI4-Stream rules: data stays stable while valid is
// high and not yet accepted.
module pr_in_ctrl
    import pkt_router_pkg::*;
#(
    parameter int N_OUT = 6,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DW-1:0]    s_tdata,
    input  logic             s_tvalid,
    input  logic             s_tlast,
    output logic             s_tready,
    input  logic [N_OUT-1:0] lut_mask,
    input  logic             grant,
    input  logic [N_OUT-1:0] m_tready,
    output logic             wait_req,
    output logic [N_OUT-1:0] hold_mask,
    output logic [N_OUT-1:0] fwd_valid,
    output logic             par_err
);
    in_state_e        state;
    logic [N_OUT-1:0] done;
    logic             hdr_ok;
    logic             route_ok;
    logic             beat_go;

    assign hdr_ok   = ^s_tdata;
    assign route_ok = hdr_ok && (lut_mask != '0);
    assign beat_go  = s_tvalid && s_tready;
    assign wait_req = (state == ST_WAIT);
    assign par_err  = (state == ST_IDLE) && s_tvalid && !hdr_ok;

    // Ready and per-destination valid for the current word.
    always_comb begin
        s_tready  = 1'b0;
        fwd_valid = '0;
        case (state)
            ST_IDLE: s_tready = s_tvalid && !route_ok;
            ST_WAIT: s_tready = 1'b0;
            ST_XFER: begin
                fwd_valid = {N_OUT{s_tvalid}} & hold_mask & ~done;
                s_tready  = s_tvalid && (&(~hold_mask | done | m_tready));
            end
            default: s_tready = 1'b1;
        endcase
    end

    // Step through the packet life cycle and record partial deliveries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            hold_mask <= '0;
            done      <= '0;
        end else begin
            case (state)
                ST_IDLE: if (s_tvalid) begin
                    if (route_ok) begin
                        hold_mask <= lut_mask;
                        state     <= ST_WAIT;
                    end else if (!s_tlast) begin
                        state <= ST_DROP;
                    end
                end
                ST_WAIT: if (grant) begin
                    done  <= '0;
                    state <= ST_XFER;
                end
                ST_XFER: begin
                    if (beat_go) begin
                        done <= '0;
                        if (s_tlast) state <= ST_IDLE;
                    end else begin
                        done <= done | (fwd_valid & m_tready);
                    end
                end
                default: if (s_tvalid && s_tlast) state <= ST_IDLE;
            endcase
        end
    end

    AST_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT || (state == ST_XFER && !(beat_go && s_tlast))) |=> $stable(hold_mask))
        else $error("mask changed mid packet"); // R2
endmodule

// File: rtl/pr_alloc.sv
// Module pr_alloc
// Keeps a lock for each output: a busy bit and the index of the input that owns it.
// Each cycle it grants waiting inputs in round-robin order. An input is granted only
// when every output in its mask is free, and all of those outputs are granted to it
// at once. A lock is released on the cycle the owner's TLAST word leaves that output.
// Assumes wait_req only rises with a non-zero mask.
module pr_alloc #(
    parameter int N_IN  = 4,
    parameter int N_OUT = 6
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [N_IN-1:0]                   wait_req,
    input  logic [N_IN-1:0][N_OUT-1:0]        req_mask,
    input  logic [N_OUT-1:0]                  rel,
    output logic [N_IN-1:0]                   grant,
    output logic [N_OUT-1:0][((N_IN > 1) ? $clog2(N_IN) : 1)-1:0] owner,
    output logic [N_OUT-1:0]                  locked
);
    localparam int IW = (N_IN > 1) ? $clog2(N_IN) : 1;

    logic [IW-1:0]            ptr;
    logic [N_OUT-1:0]         busy;
    logic [N_OUT-1:0]         take;
    logic [N_OUT-1:0][IW-1:0] take_own;
    logic                     found;
    logic [IW-1:0]            first;

    // Round-robin sweep that grants whole masks without overlap.
    always_comb begin
        int idx;
        busy     = locked;
        grant    = '0;
        take     = '0;
        take_own = '0;
        found    = 1'b0;
        first    = '0;
        for (int k = 0; k < N_IN; k++) begin
            idx = int'(ptr) + k;
            if (idx >= N_IN) idx = idx - N_IN;
            if (wait_req[idx] && ((req_mask[idx] & busy) == '0)) begin
                grant[idx] = 1'b1;
                busy       = busy | req_mask[idx];
                for (int d = 0; d < N_OUT; d++) begin
                    if (req_mask[idx][d]) begin
                        take[d]     = 1'b1;
                        take_own[d] = IW'(idx);
                    end
                end
                if (!found) begin
                    found = 1'b1;
                    first = IW'(idx);
                end
            end
        end
    end

    // Update the locks, owners and round-robin pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked <= '0;
            owner  <= '0;
            ptr    <= '0;
        end else begin
            locked <= take | (locked & ~rel);
            for (int d = 0; d < N_OUT; d++)
                if (take[d]) owner[d] <= take_own[d];
            if (found)
                ptr <= (first == IW'(N_IN - 1)) ? '0 : first + 1'b1;
        end
    end

    for (genvar d = 0; d < N_OUT; d++) begin : g_chk
        AST_OWNER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
            (locked[d] && !rel[d]) |=> (locked[d] && $stable(owner[d])))
            else $error("output %0d lost its owner mid packet", d); // R5
    end
endmodule

// File: rtl/pkt_router.sv
// Module pkt_router
// Top of the packet router. It holds the routing table, one controller per input,
// the output allocator, the output multiplexers and the sticky parity error flag.
// Assumes the inputs follow AXI4-Stream rules and the header sits in the first
// word of every packet.
module pkt_router
    import pkt_router_pkg::*;
#(
    parameter int N_IN  = 4,
    parameter int N_OUT = 6,
    parameter int DW    = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_IN*DW-1:0]    s_tdata,
    input  logic [N_IN-1:0]       s_tvalid,
    input  logic [N_IN-1:0]       s_tlast,
    output logic [N_IN-1:0]       s_tready,
    output logic [N_OUT*DW-1:0]   m_tdata,
    output logic [N_OUT-1:0]      m_tvalid,
    output logic [N_OUT-1:0]      m_tlast,
    input  logic [N_OUT-1:0]      m_tready,
    input  logic                  cfg_we,
    input  logic [SID_W-1:0]      cfg_id,
    input  logic [N_OUT-1:0]      cfg_mask,
    output logic                  hdr_err
);
    localparam int IW = (N_IN > 1) ? $clog2(N_IN) : 1;

    logic [N_IN-1:0][DW-1:0]     s_data_a;
    logic [N_IN-1:0][SID_W-1:0]  sid;
    logic [N_IN-1:0][N_OUT-1:0]  lut_mask;
    logic [N_IN-1:0][N_OUT-1:0]  hold_mask;
    logic [N_IN-1:0][N_OUT-1:0]  fwd_valid;
    logic [N_IN-1:0]             wait_req;
    logic [N_IN-1:0]             grant;
    logic [N_IN-1:0]             par_err;
    logic [N_OUT-1:0][IW-1:0]    owner;
    logic [N_OUT-1:0]            locked;
    logic [N_OUT-1:0]            rel;
    logic [N_OUT-1:0][DW-1:0]    m_data_a;

    assign s_data_a = s_tdata;
    assign m_tdata  = m_data_a;

    for (genvar i = 0; i < N_IN; i++) begin : g_in
        assign sid[i] = s_data_a[i][SID_W-1:0];

        pr_in_ctrl #(.N_OUT(N_OUT), .DW(DW)) u_in (
            .clk       (clk),
            .rst_n     (rst_n),
            .s_tdata   (s_data_a[i]),
            .s_tvalid  (s_tvalid[i]),
            .s_tlast   (s_tlast[i]),
            .s_tready  (s_tready[i]),
            .lut_mask  (lut_mask[i]),
            .grant     (grant[i]),
            .m_tready  (m_tready),
            .wait_req  (wait_req[i]),
            .hold_mask (hold_mask[i]),
            .fwd_valid (fwd_valid[i]),
            .par_err   (par_err[i])
        );
    end

    pr_id_table #(.N_OUT(N_OUT), .ID_W(SID_W), .N_RD(N_IN)) u_tbl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_id   (cfg_id),
        .wr_mask (cfg_mask),
        .rd_id   (sid),
        .rd_mask (lut_mask)
    );

    pr_alloc #(.N_IN(N_IN), .N_OUT(N_OUT)) u_alloc (
        .clk      (clk),
        .rst_n    (rst_n),
        .wait_req (wait_req),
        .req_mask (hold_mask),
        .rel      (rel),
        .grant    (grant),
        .owner    (owner),
        .locked   (locked)
    );

    for (genvar d = 0; d < N_OUT; d++) begin : g_out
        logic [N_IN-1:0] gcol;

        // Route the owning input's word to this output.
        assign m_data_a[d] = s_data_a[owner[d]];
        assign m_tlast[d]  = s_tlast[owner[d]];
        assign m_tvalid[d] = locked[d] && fwd_valid[owner[d]][d];
        assign rel[d]      = m_tvalid[d] && m_tready[d] && m_tlast[d];

        for (genvar i = 0; i < N_IN; i++) begin : g_col
            assign gcol[i] = grant[i] && hold_mask[i][d];
        end

        AST_MVALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (m_tvalid[d] && !m_tready[d]) |=> (m_tvalid[d] && $stable(m_data_a[d])))
            else $error("output %0d dropped a pending word", d); // R8
        AST_GRANT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(gcol))
            else $error("output %0d granted twice", d); // R5
    end

    // Latch any header parity failure until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hdr_err <= 1'b0;
        else if (|par_err)
            hdr_err <= 1'b1;
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_err |=> hdr_err)
        else $error("error flag cleared"); // R1
endmodule

// File: tb/tb_pkt_router.sv
module tb_pkt_router;
    localparam int N_IN  = 4;
    localparam int N_OUT = 6;
    localparam int DW    = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [N_IN*DW-1:0]  s_tdata;
    logic [N_IN-1:0]     s_tvalid, s_tlast, s_tready;
    logic [N_OUT*DW-1:0] m_tdata;
    logic [N_OUT-1:0]    m_tvalid, m_tlast;
    logic [N_OUT-1:0]    m_tready = '1;
    logic                cfg_we = 1'b0;
    logic [4:0]          cfg_id = '0;
    logic [N_OUT-1:0]    cfg_mask = '0;
    logic                hdr_err;

    logic [DW-1:0] drv_data  [N_IN];
    logic          drv_valid [N_IN];
    logic          drv_last  [N_IN];

    always_comb begin
        for (int i = 0; i < N_IN; i++) begin
            s_tdata[i*DW +: DW] = drv_data[i];
            s_tvalid[i]         = drv_valid[i];
            s_tlast[i]          = drv_last[i];
        end
    end

    pkt_router #(.N_IN(N_IN), .N_OUT(N_OUT), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n),
        .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tlast(s_tlast), .s_tready(s_tready),
        .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tlast(m_tlast), .m_tready(m_tready),
        .cfg_we(cfg_we), .cfg_id(cfg_id), .cfg_mask(cfg_mask), .hdr_err(hdr_err)
    );

    int checks = 0;
    int errors = 0;
    logic [N_OUT-1:0] tbl [32];
    int exp_cnt [N_OUT];
    int rcv_cnt [N_OUT];
    int seq_ctr [N_IN];
    int rr_log  [16];
    int rr_n = 0;
    bit rnd_ready = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] hdr_word(input int src, input int seq, input int id,
                                              input int len, input bit bad);
        logic [31:0] w;
        w = {1'b0, 3'b000, 7'(seq), 5'(src), 1'b0, 3'(len), 7'b0, 5'(id)};
        w[31] = ~(^w[30:0]);
        if (bad) w[31] = ~w[31];
        return w;
    endfunction

    function automatic logic [31:0] data_word(input int src, input int seq, input int k);
        return {4'(src), 12'(seq), 16'(k)} ^ 32'h0F0F_0000;
    endfunction

    task automatic send(input int src, input int id, input int len, input bit bad);
        int seq;
        seq = seq_ctr[src];
        seq_ctr[src] = (seq_ctr[src] + 1) % 128;
        for (int k = 0; k <= len; k++) begin
            drv_data[src]  = (k == 0) ? hdr_word(src, seq, id, len, bad) : data_word(src, seq, k);
            drv_last[src]  = (k == len);
            drv_valid[src] = 1'b1;
            @(negedge clk);
            while (!s_tready[src]) @(negedge clk);
            @(posedge clk);
            #1;
        end
        drv_valid[src] = 1'b0;
        drv_last[src]  = 1'b0;
        if (!bad)
            for (int d = 0; d < N_OUT; d++)
                if (tbl[id][d]) exp_cnt[d]++;
    endtask

    task automatic cfg_write(input int id, input logic [N_OUT-1:0] mask);
        cfg_we = 1'b1; cfg_id = 5'(id); cfg_mask = mask;
        @(posedge clk); #1;
        cfg_we = 1'b0;
        tbl[id] = mask;
    endtask

    task automatic drain();
        repeat (60) @(posedge clk);
        #1;
    endtask

    // Output monitor: rebuilds each packet from its header and checks every word.
    bit in_pkt [N_OUT];
    int cur_src [N_OUT], cur_seq [N_OUT], cur_len [N_OUT], cur_k [N_OUT];
    logic [31:0] mon_w;
    always @(negedge clk) begin
        if (rst_n) begin
            for (int d = 0; d < N_OUT; d++) begin
                if (m_tvalid[d] && m_tready[d]) begin
                    mon_w = m_tdata[d*DW +: DW];
                    if (!in_pkt[d]) begin
                        chk(^mon_w == 1'b1, "R4 header unchanged (odd parity)", mon_w, mon_w);
                        chk(tbl[mon_w[4:0]][d] == 1'b1, "R2 output in table mask",
                            32'(tbl[mon_w[4:0]]), 32'(d));
                        cur_src[d] = int'(mon_w[20:16]);
                        cur_seq[d] = int'(mon_w[27:21]);
                        cur_len[d] = int'(mon_w[14:12]);
                        cur_k[d]   = 0;
                        in_pkt[d]  = 1'b1;
                    end else begin
                        cur_k[d]++;
                        chk(mon_w == data_word(cur_src[d], cur_seq[d], cur_k[d]),
                            "R5 data word in order, no interleave", mon_w,
                            data_word(cur_src[d], cur_seq[d], cur_k[d]));
                    end
                    chk(m_tlast[d] == (cur_k[d] == cur_len[d]), "R4 tlast on last word",
                        32'(m_tlast[d]), 32'(cur_k[d] == cur_len[d]));
                    if (m_tlast[d]) begin
                        in_pkt[d] = 1'b0;
                        rcv_cnt[d]++;
                        if (d == 0 && rr_n < 16) begin
                            rr_log[rr_n] = cur_src[d];
                            rr_n++;
                        end
                    end
                end
            end
        end
    end

    // Random downstream backpressure.
    initial begin
        forever begin
            @(posedge clk); #1;
            if (rnd_ready)
                for (int d = 0; d < N_OUT; d++) m_tready[d] = (($urandom % 10) < 7);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R6 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    int snap [N_OUT];

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < N_IN; i++) begin
            drv_data[i] = '0; drv_valid[i] = 1'b0; drv_last[i] = 1'b0; seq_ctr[i] = 0;
        end
        for (int d = 0; d < N_OUT; d++) begin
            exp_cnt[d] = 0; rcv_cnt[d] = 0; in_pkt[d] = 1'b0;
        end
        for (int t = 0; t < 32; t++) tbl[t] = '0;

        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(m_tvalid == '0, "R9 outputs idle in reset", 32'(m_tvalid), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk(m_tvalid == '0, "R9 outputs idle after reset", 32'(m_tvalid), 0);
        chk(s_tready == '0, "R9 inputs not ready while idle", 32'(s_tready), 0);
        chk(hdr_err == 1'b0, "R9 error flag clear", 32'(hdr_err), 0);
        @(posedge clk); #1;

        cfg_write(1, 6'b000001);
        cfg_write(2, 6'b000110);
        cfg_write(3, 6'b000000);

        // Unicast and multicast with all outputs ready.
        send(0, 1, 2, 1'b0);
        send(1, 2, 3, 1'b0);
        drain();
        chk(rcv_cnt[0] == 1 && rcv_cnt[1] == 1 && rcv_cnt[2] == 1,
            "R6 unicast and multicast delivered", 32'(rcv_cnt[1]), 1);

        // Multicast with one destination stalled.
        m_tready = 6'b111101;
        fork send(0, 2, 3, 1'b0); join_none
        repeat (8) @(posedge clk);
        @(negedge clk);
        chk(m_tvalid[1] == 1'b1, "R8 stalled output keeps valid", 32'(m_tvalid[1]), 1);
        chk(m_tdata[1*DW +: DW] == hdr_word(0, 1, 2, 3, 1'b0), "R4 stalled output holds header",
            m_tdata[1*DW +: DW], hdr_word(0, 1, 2, 3, 1'b0));
        chk(m_tvalid[2] == 1'b0, "R6 taken word not offered again", 32'(m_tvalid[2]), 0);
        chk(s_tready[0] == 1'b0, "R6 input held by stalled destination", 32'(s_tready[0]), 0);
        @(posedge clk); #1;
        m_tready = '1;
        wait fork;
        drain();
        chk(rcv_cnt[1] == 2 && rcv_cnt[2] == 2, "R6 multicast completes after stall",
            32'(rcv_cnt[2]), 2);

        // Zero mask: silent discard.
        for (int d = 0; d < N_OUT; d++) snap[d] = rcv_cnt[d];
        send(1, 3, 4, 1'b0);
        drain();
        for (int d = 0; d < N_OUT; d++)
            chk(rcv_cnt[d] == snap[d], "R3 zero mask delivers nothing", 32'(rcv_cnt[d]), 32'(snap[d]));
        chk(hdr_err == 1'b0, "R3 zero mask raises no error", 32'(hdr_err), 0);

        // Table rewrite takes effect for later packets.
        cfg_write(4, 6'b100000);
        send(3, 4, 1, 1'b0);
        drain();
        chk(rcv_cnt[5] == 1, "R2 new entry routes to output 5", 32'(rcv_cnt[5]), 1);

        // Round robin: three inputs queue behind a long packet on output 0.
        rr_n = 0;
        m_tready = 6'b111110;
        fork send(3, 1, 7, 1'b0); join_none
        repeat (5) @(posedge clk);
        #1;
        for (int s = 0; s < 3; s++) begin
            fork
                automatic int src = s;
                begin send(src, 1, 1, 1'b0); send(src, 1, 1, 1'b0); end
            join_none
        end
        repeat (10) @(posedge clk);
        #1;
        m_tready = '1;
        wait fork;
        drain();
        chk(rr_n == 7, "R7 all queued packets delivered", 32'(rr_n), 7);
        chk(rr_log[0] == 3, "R7 locked owner finishes first", 32'(rr_log[0]), 3);
        chk(rr_log[1] != rr_log[2] && rr_log[2] != rr_log[3] && rr_log[1] != rr_log[3],
            "R7 first round serves each waiter once", 32'(rr_log[2]), 32'(rr_log[1]));
        chk(rr_log[4] != rr_log[5] && rr_log[5] != rr_log[6] && rr_log[4] != rr_log[6],
            "R7 second round serves each waiter once", 32'(rr_log[5]), 32'(rr_log[4]));

        // Bad parity: whole packet dropped, flag set, next packet flows.
        for (int d = 0; d < N_OUT; d++) snap[d] = rcv_cnt[d];
        send(2, 1, 3, 1'b1);
        drain();
        chk(rcv_cnt[0] == snap[0], "R1 bad parity packet dropped", 32'(rcv_cnt[0]), 32'(snap[0]));
        chk(hdr_err == 1'b1, "R1 error flag set", 32'(hdr_err), 1);
        send(2, 1, 2, 1'b0);
        drain();
        chk(rcv_cnt[0] == snap[0] + 1, "R1 drop ends at tlast", 32'(rcv_cnt[0]), 32'(snap[0] + 1));

        // Random traffic under random backpressure.
        for (int t = 8; t < 16; t++) cfg_write(t, N_OUT'($urandom % 64));
        rnd_ready = 1'b1;
        for (int s = 0; s < N_IN; s++) begin
            fork
                automatic int src = s;
                begin
                    for (int p = 0; p < 25; p++) begin
                        int r;
                        r = int'($urandom % 11);
                        repeat ($urandom % 3) @(posedge clk);
                        #1;
                        send(src, (r < 3) ? r + 1 : r + 5, int'($urandom % 8), (($urandom % 16) == 0));
                    end
                end
            join_none
        end
        wait fork;
        rnd_ready = 1'b0;
        m_tready = '1;
        drain();
        for (int d = 0; d < N_OUT; d++)
            chk(rcv_cnt[d] == exp_cnt[d], "R6 packet count per output", 32'(rcv_cnt[d]), 32'(exp_cnt[d]));
        chk(hdr_err == 1'b1, "R1 error flag sticky", 32'(hdr_err), 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule